// File: doc/BRIEF.md
# Dual-Clock Bidirectional FIFO Pair

This block joins two clock domains through a pair of first-in first-out queues that run in opposite directions. Port A lives on its own clock and port B on another; each port carries a 36-bit data input, a 36-bit data output and four control inputs (active-low select, direction, mailbox select and enable). The same four controls decide whether a port cycle writes the queue that leaves the port or reads the queue that arrives at it. Lane 0 moves words from A to B and lane 1 moves words from B to A. Each lane holds `DEPTH` words (64 by default).

Every reader side has an output register that is filled ahead of demand. When a word lands in an empty lane, the reader's empty flag rises a few reader clocks later with that word already on the output. A read enable then consumes the shown word and pulls the next one forward. The reader side is a two-state machine: `RD_DRY` (nothing shown, empty flag low) and `RD_HELD` (a word is shown, empty flag high). Its transitions are named `LOAD_FIRST` (`RD_DRY` to `RD_HELD` when the memory holds data), `LOAD_NEXT` (stay in `RD_HELD` on a read when more data is stored), `DRAIN` (`RD_HELD` to `RD_DRY` on a read with nothing left) and `WAIT` (no change). Pointers cross between the clocks in Gray code through two flops each. Full is judged from the writer's view of the reader's consumed count, and empty from the reader's view of the write pointer. The output tri-state is represented by a data-valid output.

Top module: `bififo_pair`

## Requirements
- R1: While reset is held and after it is released with no traffic, each port shows its empty flag low, its full flag high and its almost-empty flag low.
- R2: A port writes its outgoing lane on its clock edge only when select is low, direction is 1, mailbox select is 0 and enable is 1. Any other combination stores nothing.
- R3: A port reads its incoming lane only when select is low, direction is 0, mailbox select is 0 and enable is 1. A read attempted with mailbox select 1 consumes nothing.
- R4: After a word is written into an empty lane, the reader's empty flag goes high within 8 reader clocks, and that word is already on the reader's data output.
- R5: After `DEPTH` accepted writes with no reads, the writer's full flag is low. After one read, it goes high again within 8 writer clocks.
- R6: A write while full and a read while empty are ignored. No word is stored or lost, and the data output does not change.
- R7: The reader's almost-empty flag is low while the lane holds `AE_LEVEL` (default 8) or fewer words, counting the word on the output register. It is high once `AE_LEVEL`+1 words are held.
- R8: The output register keeps its word until a read is enabled. Words leave in the order they were written.
- R9: Traffic through one lane leaves the other lane's flags and data untouched.
- R10: A port's data-valid output is 1 exactly when its select is low and its direction is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a | input | 1 | Port A synchronous reset, active high |
| sel_a_n | input | 1 | Port A select, active low |
| dir_a | input | 1 | Port A direction: 1 write, 0 read |
| mbx_a | input | 1 | Port A mailbox select; 1 blocks queue access |
| en_a | input | 1 | Port A enable |
| din_a | input | 36 | Port A write data (into lane 0) |
| dout_a | output | 36 | Port A output register (from lane 1) |
| dvld_a | output | 1 | Port A data output valid |
| full_a_n | output | 1 | Lane 0 full, active low |
| empty_a_n | output | 1 | Lane 1 empty, active low |
| aempty_a_n | output | 1 | Lane 1 almost empty, active low |
| clk_b | input | 1 | Port B clock |
| rst_b | input | 1 | Port B synchronous reset, active high |
| sel_b_n | input | 1 | Port B select, active low |
| dir_b | input | 1 | Port B direction: 1 write, 0 read |
| mbx_b | input | 1 | Port B mailbox select; 1 blocks queue access |
| en_b | input | 1 | Port B enable |
| din_b | input | 36 | Port B write data (into lane 1) |
| dout_b | output | 36 | Port B output register (from lane 0) |
| dvld_b | output | 1 | Port B data output valid |
| full_b_n | output | 1 | Lane 1 full, active low |
| empty_b_n | output | 1 | Lane 0 empty, active low |
| aempty_b_n | output | 1 | Lane 0 almost empty, active low |

## Verification
A wrong pointer or a wrong Gray crossing first shows as a flag that rises too late, too early or never. The bench waits a bounded number of clocks for each flag and counts a miss against the relevant requirement. A miscounted read pointer shows at the next read as a word out of order or repeated, because every word carries its own index. A reader machine left in the wrong state shows at once as an empty flag that disagrees with the data on the output register. A full flag that is off by one shows when the extra write is later read back.

// File: rtl/bififo_pkg.sv
package bififo_pkg;

    typedef enum logic [0:0] {
        RD_DRY  = 1'b0,
        RD_HELD = 1'b1
    } rd_state_e;

    typedef struct packed {
        logic wr;
        logic rd;
    } port_cmd_t;

endpackage

// File: rtl/bififo_sync.sv
module bififo_sync #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            hold_q <= '0;
        end else begin
            meta_q <= d;
            hold_q <= meta_q;
        end
    end

    assign q = hold_q;
endmodule

// File: rtl/bififo_port_decode.sv
module bififo_port_decode
    import bififo_pkg::*;
(
    input  logic      sel_n,
    input  logic      dir,
    input  logic      mbx,
    input  logic      en,
    output port_cmd_t cmd,
    output logic      dvld
);
    always_comb begin
        cmd.wr = !sel_n && dir  && !mbx && en;
        cmd.rd = !sel_n && !dir && !mbx && en;
        dvld   = !sel_n && !dir;
    end
endmodule

// File: rtl/bififo_wr_side.sv
module bififo_wr_side #(
    parameter int DEPTH = 64
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_req,
    input  logic [$clog2(DEPTH):0]       rgray_s,
    output logic                         we,
    output logic [$clog2(DEPTH)-1:0]     waddr,
    output logic [$clog2(DEPTH):0]       wgray,
    output logic                         full_n
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;
    localparam logic [PW-1:0] DEPTH_W = PW'(DEPTH);

    logic [PW-1:0] wptr_q;
    logic [PW-1:0] wgray_q;
    logic [PW-1:0] rbin;
    logic [PW-1:0] used;
    logic [PW-1:0] wnext;

    always_comb begin
        rbin[PW-1] = rgray_s[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            rbin[i] = rbin[i+1] ^ rgray_s[i];
        end
    end

    assign used   = wptr_q - rbin;
    assign full_n = (used != DEPTH_W);
    assign we     = wr_req && full_n;
    assign wnext  = wptr_q + PW'(we);
    assign waddr  = wptr_q[AW-1:0];
    assign wgray  = wgray_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr_q  <= '0;
            wgray_q <= '0;
        end else begin
            wptr_q  <= wnext;
            wgray_q <= wnext ^ (wnext >> 1);
        end
    end

    AST_WR_FULL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr_req && !full_n) |=> $stable(wptr_q)); // R6
    AST_WR_GRAY_STEP: assert property (@(posedge clk) disable iff (rst)
        $countones(wgray_q ^ $past(wgray_q)) <= 1); // R5
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        used <= DEPTH_W); // R5
endmodule

// File: rtl/bififo_rd_side.sv
module bififo_rd_side
    import bififo_pkg::*;
#(
    parameter int DEPTH    = 64,
    parameter int WIDTH    = 36,
    parameter int AE_LEVEL = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     rd_req,
    input  logic [$clog2(DEPTH):0]   wgray_s,
    input  logic [WIDTH-1:0]         mem_rdata,
    output logic [$clog2(DEPTH)-1:0] raddr,
    output logic [$clog2(DEPTH):0]   rgray,
    output logic [WIDTH-1:0]         dout,
    output logic                     empty_n,
    output logic                     aempty_n
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;
    localparam logic [PW-1:0] AE_W = PW'(AE_LEVEL);

    rd_state_e      state_q, state_d;
    logic [PW-1:0]  rptr_q, rptr_d;
    logic [PW-1:0]  rgray_q;
    logic [PW-1:0]  commit_d;
    logic [PW-1:0]  wbin;
    logic [PW-1:0]  level;
    logic [WIDTH-1:0] dout_q;
    logic           mem_has;
    logic           load;

    always_comb begin
        wbin[PW-1] = wgray_s[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            wbin[i] = wbin[i+1] ^ wgray_s[i];
        end
    end

    assign mem_has = (wbin != rptr_q);

    // next-state process: LOAD_FIRST, LOAD_NEXT, DRAIN, WAIT
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        unique case (state_q)
            RD_DRY: begin
                if (mem_has) begin
                    load    = 1'b1;
                    state_d = RD_HELD;
                end
            end
            RD_HELD: begin
                if (rd_req) begin
                    if (mem_has) begin
                        load = 1'b1;
                    end else begin
                        state_d = RD_DRY;
                    end
                end
            end
            default: state_d = RD_DRY;
        endcase
        rptr_d   = rptr_q + PW'(load);
        commit_d = rptr_d - PW'(state_d == RD_HELD);
    end

    // state register process
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RD_DRY;
            rptr_q  <= '0;
            rgray_q <= '0;
        end else begin
            state_q <= state_d;
            rptr_q  <= rptr_d;
            rgray_q <= commit_d ^ (commit_d >> 1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dout_q <= '0;
        end else if (load) begin
            dout_q <= mem_rdata;
        end
    end

    // output process
    always_comb begin
        level    = (wbin - rptr_q) + PW'(state_q == RD_HELD);
        empty_n  = (state_q == RD_HELD);
        aempty_n = (level > AE_W);
        raddr    = rptr_q[AW-1:0];
        rgray    = rgray_q;
        dout     = dout_q;
    end

    AST_RD_EMPTY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !empty_n) |=> $stable(dout_q)); // R6
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!rd_req && empty_n) |=> ($stable(dout_q) && empty_n)); // R8
    AST_RD_GRAY_STEP: assert property (@(posedge clk) disable iff (rst)
        $countones(rgray_q ^ $past(rgray_q)) <= 1); // R5
endmodule

// File: rtl/bififo_lane.sv
module bififo_lane #(
    parameter int DEPTH    = 64,
    parameter int WIDTH    = 36,
    parameter int AE_LEVEL = 8
) (
    input  logic             wclk,
    input  logic             wrst,
    input  logic             wr_req,
    input  logic [WIDTH-1:0] wdata,
    output logic             full_n,
    input  logic             rclk,
    input  logic             rrst,
    input  logic             rd_req,
    output logic [WIDTH-1:0] rdata,
    output logic             empty_n,
    output logic             aempty_n
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic             we;
    logic [AW-1:0]    waddr, raddr;
    logic [PW-1:0]    wgray, wgray_s, rgray, rgray_s;

    always_ff @(posedge wclk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    bififo_wr_side #(.DEPTH(DEPTH)) u_wr (
        .clk    (wclk),
        .rst    (wrst),
        .wr_req (wr_req),
        .rgray_s(rgray_s),
        .we     (we),
        .waddr  (waddr),
        .wgray  (wgray),
        .full_n (full_n)
    );

    bififo_sync #(.W(PW)) u_w2r (
        .clk(rclk), .rst(rrst), .d(wgray), .q(wgray_s)
    );

    bififo_sync #(.W(PW)) u_r2w (
        .clk(wclk), .rst(wrst), .d(rgray), .q(rgray_s)
    );

    bififo_rd_side #(
        .DEPTH(DEPTH), .WIDTH(WIDTH), .AE_LEVEL(AE_LEVEL)
    ) u_rd (
        .clk      (rclk),
        .rst      (rrst),
        .rd_req   (rd_req),
        .wgray_s  (wgray_s),
        .mem_rdata(mem[raddr]),
        .raddr    (raddr),
        .rgray    (rgray),
        .dout     (rdata),
        .empty_n  (empty_n),
        .aempty_n (aempty_n)
    );
endmodule

// File: rtl/bififo_pair.sv
module bififo_pair
    import bififo_pkg::*;
#(
    parameter int DEPTH    = 64,
    parameter int WIDTH    = 36,
    parameter int AE_LEVEL = 8
) (
    input  logic             clk_a,
    input  logic             rst_a,
    input  logic             sel_a_n,
    input  logic             dir_a,
    input  logic             mbx_a,
    input  logic             en_a,
    input  logic [WIDTH-1:0] din_a,
    output logic [WIDTH-1:0] dout_a,
    output logic             dvld_a,
    output logic             full_a_n,
    output logic             empty_a_n,
    output logic             aempty_a_n,
    input  logic             clk_b,
    input  logic             rst_b,
    input  logic             sel_b_n,
    input  logic             dir_b,
    input  logic             mbx_b,
    input  logic             en_b,
    input  logic [WIDTH-1:0] din_b,
    output logic [WIDTH-1:0] dout_b,
    output logic             dvld_b,
    output logic             full_b_n,
    output logic             empty_b_n,
    output logic             aempty_b_n
);
    localparam int NPORT = 2;

    port_cmd_t        cmd   [NPORT];
    logic             clk   [NPORT];
    logic             rst   [NPORT];
    logic [WIDTH-1:0] din   [NPORT];
    logic [WIDTH-1:0] dout  [NPORT];
    logic             full  [NPORT];
    logic             empty [NPORT];
    logic             aemp  [NPORT];

    assign clk[0] = clk_a;
    assign clk[1] = clk_b;
    assign rst[0] = rst_a;
    assign rst[1] = rst_b;
    assign din[0] = din_a;
    assign din[1] = din_b;

    bififo_port_decode u_dec_a (
        .sel_n(sel_a_n), .dir(dir_a), .mbx(mbx_a), .en(en_a),
        .cmd(cmd[0]), .dvld(dvld_a)
    );

    bififo_port_decode u_dec_b (
        .sel_n(sel_b_n), .dir(dir_b), .mbx(mbx_b), .en(en_b),
        .cmd(cmd[1]), .dvld(dvld_b)
    );

    // lane i is written from port i and read at the opposite port
    for (genvar i = 0; i < NPORT; i++) begin : g_lane
        localparam int RP = NPORT - 1 - i;
        bififo_lane #(
            .DEPTH(DEPTH), .WIDTH(WIDTH), .AE_LEVEL(AE_LEVEL)
        ) u_lane (
            .wclk    (clk[i]),
            .wrst    (rst[i]),
            .wr_req  (cmd[i].wr),
            .wdata   (din[i]),
            .full_n  (full[i]),
            .rclk    (clk[RP]),
            .rrst    (rst[RP]),
            .rd_req  (cmd[RP].rd),
            .rdata   (dout[RP]),
            .empty_n (empty[RP]),
            .aempty_n(aemp[RP])
        );
    end

    assign full_a_n   = full[0];
    assign full_b_n   = full[1];
    assign dout_a     = dout[0];
    assign dout_b     = dout[1];
    assign empty_a_n  = empty[0];
    assign empty_b_n  = empty[1];
    assign aempty_a_n = aemp[0];
    assign aempty_b_n = aemp[1];
endmodule

// File: tb/test_bififo_pair.sv
module test_bififo_pair;
    localparam int DEPTH = 64;
    localparam int W     = 36;
    localparam int AE    = 8;

    logic clk_a = 1'b0, clk_b = 1'b0;
    logic rst_a, rst_b;
    logic sel_a_n, dir_a, mbx_a, en_a;
    logic sel_b_n, dir_b, mbx_b, en_b;
    logic [W-1:0] din_a, din_b, dout_a, dout_b;
    logic dvld_a, dvld_b, full_a_n, full_b_n;
    logic empty_a_n, empty_b_n, aempty_a_n, aempty_b_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk_a = ~clk_a;
    initial begin
        #7;
        forever #10 clk_b = ~clk_b;
    end

    bififo_pair #(.DEPTH(DEPTH), .WIDTH(W), .AE_LEVEL(AE)) i_bififo_pair (
        .clk_a(clk_a), .rst_a(rst_a), .sel_a_n(sel_a_n), .dir_a(dir_a),
        .mbx_a(mbx_a), .en_a(en_a), .din_a(din_a), .dout_a(dout_a),
        .dvld_a(dvld_a), .full_a_n(full_a_n), .empty_a_n(empty_a_n),
        .aempty_a_n(aempty_a_n),
        .clk_b(clk_b), .rst_b(rst_b), .sel_b_n(sel_b_n), .dir_b(dir_b),
        .mbx_b(mbx_b), .en_b(en_b), .din_b(din_b), .dout_b(dout_b),
        .dvld_b(dvld_b), .full_b_n(full_b_n), .empty_b_n(empty_b_n),
        .aempty_b_n(aempty_b_n)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    function automatic logic [W-1:0] word(input int tag, input int i);
        return {4'(tag), 32'(i)};
    endfunction

    task automatic idle_a(); sel_a_n = 1; dir_a = 0; mbx_a = 0; en_a = 0; endtask
    task automatic idle_b(); sel_b_n = 1; dir_b = 0; mbx_b = 0; en_b = 0; endtask

    task automatic port_a(input bit dir, input bit mbx, input bit sel_n,
                          input bit en, input logic [W-1:0] d);
        @(negedge clk_a);
        sel_a_n = sel_n; dir_a = dir; mbx_a = mbx; en_a = en; din_a = d;
        @(negedge clk_a);
        idle_a();
    endtask

    task automatic port_b(input bit dir, input bit mbx, input bit sel_n,
                          input bit en, input logic [W-1:0] d);
        @(negedge clk_b);
        sel_b_n = sel_n; dir_b = dir; mbx_b = mbx; en_b = en; din_b = d;
        @(negedge clk_b);
        idle_b();
    endtask

    task automatic wait_b(input int n);
        for (int i = 0; i < n; i++) @(negedge clk_b);
    endtask

    task automatic wait_a(input int n);
        for (int i = 0; i < n; i++) @(negedge clk_a);
    endtask

    task automatic t_reset();
        @(negedge clk_a);
        chk(empty_a_n == 0 && empty_b_n == 0, "R1 empty low in reset", {34'b0, empty_a_n, empty_b_n}, 0);
        chk(full_a_n == 1 && full_b_n == 1, "R1 full high in reset", {34'b0, full_a_n, full_b_n}, 3);
        rst_a = 0; rst_b = 0;
        wait_b(4);
        chk(aempty_a_n == 0 && aempty_b_n == 0, "R1 almost-empty low", {34'b0, aempty_a_n, aempty_b_n}, 0);
        chk(empty_a_n == 0 && empty_b_n == 0 && full_a_n && full_b_n, "R1 idle flags",
            {32'b0, empty_a_n, empty_b_n, full_a_n, full_b_n}, 3);
    endtask

    task automatic t_valid();
        @(negedge clk_a);
        sel_a_n = 0; dir_a = 0; #1;
        chk(dvld_a == 1, "R10 valid on read select", {35'b0, dvld_a}, 1);
        dir_a = 1; #1;
        chk(dvld_a == 0, "R10 no valid in write dir", {35'b0, dvld_a}, 0);
        sel_a_n = 1; dir_a = 0; #1;
        chk(dvld_a == 0, "R10 no valid deselected", {35'b0, dvld_a}, 0);
        idle_a();
    endtask

    task automatic t_first_word();
        logic [W-1:0] w0;
        int n;
        w0 = word(10, 1);
        port_a(1, 0, 0, 1, w0);
        n = 0;
        while (!empty_b_n && n < 8) begin @(negedge clk_b); n++; end
        chk(empty_b_n == 1, "R4 empty rises after write", {35'b0, empty_b_n}, 1);
        chk(dout_b == w0, "R4 first word shown", dout_b, w0);
        wait_b(3);
        chk(dout_b == w0 && empty_b_n, "R8 output held without read", dout_b, w0);
        port_b(0, 1, 0, 1, 0);
        chk(dout_b == w0 && empty_b_n, "R3 mailbox read consumes nothing", dout_b, w0);
        port_b(0, 0, 0, 1, 0);
        chk(empty_b_n == 0, "R3 read consumes last word", {35'b0, empty_b_n}, 0);
        chk(dout_b == w0, "R8 output kept after drain", dout_b, w0);
    endtask

    task automatic t_decode_write();
        port_a(1, 1, 0, 1, word(11, 1));
        port_a(1, 0, 1, 1, word(11, 2));
        port_a(1, 0, 0, 0, word(11, 3));
        port_a(0, 0, 0, 1, word(11, 4));
        wait_b(8);
        chk(empty_b_n == 0, "R2 blocked writes store nothing", {35'b0, empty_b_n}, 0);
    endtask

    task automatic t_almost_empty();
        for (int i = 0; i < AE; i++) port_a(1, 0, 0, 1, word(12, i));
        wait_b(8);
        chk(aempty_b_n == 0, "R7 almost-empty at level", {35'b0, aempty_b_n}, 0);
        port_a(1, 0, 0, 1, word(12, AE));
        wait_b(8);
        chk(aempty_b_n == 1, "R7 almost-empty clears above level", {35'b0, aempty_b_n}, 1);
        for (int i = 0; i <= AE; i++) begin
            chk(empty_b_n && dout_b == word(12, i), "R8 order", dout_b, word(12, i));
            port_b(0, 0, 0, 1, 0);
        end
        chk(empty_b_n == 0, "R8 drained", {35'b0, empty_b_n}, 0);
    endtask

    task automatic t_full();
        int n;
        logic [W-1:0] last;
        for (int i = 0; i < DEPTH; i++) port_a(1, 0, 0, 1, word(13, i));
        chk(full_a_n == 0, "R5 full after DEPTH writes", {35'b0, full_a_n}, 0);
        port_a(1, 0, 0, 1, word(14, 0));
        wait_b(8);
        chk(dout_b == word(13, 0), "R5 head word shown", dout_b, word(13, 0));
        port_b(0, 0, 0, 1, 0);
        n = 0;
        while (!full_a_n && n < 8) begin @(negedge clk_a); n++; end
        chk(full_a_n == 1, "R5 full clears after read", {35'b0, full_a_n}, 1);
        for (int i = 1; i < DEPTH; i++) begin
            if (!(empty_b_n && dout_b == word(13, i))) begin
                chk(0, "R6 write while full stored or lost", dout_b, word(13, i));
            end
            port_b(0, 0, 0, 1, 0);
        end
        checks++;
        wait_b(8);
        chk(empty_b_n == 0, "R6 extra write ignored", {35'b0, empty_b_n}, 0);
        last = dout_b;
        port_b(0, 0, 0, 1, 0);
        chk(dout_b == last && !empty_b_n, "R6 read while empty ignored", dout_b, last);
    endtask

    task automatic t_reverse();
        int n;
        for (int i = 0; i < 3; i++) port_b(1, 0, 0, 1, word(15, i));
        n = 0;
        while (!empty_a_n && n < 8) begin @(negedge clk_a); n++; end
        chk(empty_a_n == 1, "R4 reverse lane empty rises", {35'b0, empty_a_n}, 1);
        chk(empty_b_n == 0 && full_b_n == 1, "R9 other lane untouched",
            {34'b0, empty_b_n, full_b_n}, 1);
        for (int i = 0; i < 3; i++) begin
            chk(dout_a == word(15, i), "R9 reverse order", dout_a, word(15, i));
            port_a(0, 0, 0, 1, 0);
        end
        chk(empty_a_n == 0, "R9 reverse drained", {35'b0, empty_a_n}, 0);
    endtask

    initial begin
        rst_a = 1; rst_b = 1;
        din_a = '0; din_b = '0;
        idle_a(); idle_b();
        wait_a(3);
        t_reset();
        t_valid();
        t_first_word();
        t_decode_write();
        t_almost_empty();
        t_full();
        t_reverse();
        finish_run();
    end

    initial begin
        #2000000;
        fails++;
        checks++;
        $display("FAIL watchdog actual=%h expected=%h", 0, 1);
        finish_run();
    end
endmodule